// File: doc/BRIEF.md
# Deferred-Fault Commit and Store Recovery Unit

This unit keeps the per-register "deferred fault" flags produced by speculative (non-excepting) loads for two register banks, an integer bank and a floating bank, together with a small log of the faulting loads: destination register, bank and effective address. The load side reports each deferred fault on a record port. Later, software either commits a register or the whole bank, or only clears the flags. A commit tests the flag or flags. If a fault was pending while logging is on, the unit raises a commit exception and removes the matching log entries.

The unit also repairs speculatively loaded registers. When a recovering store is issued, its address is compared with every valid log entry, lowest index first. On the first hit the unit asks the data cache to invalidate and flush the line holding that address. It then writes the stored value straight into the logged destination register, one 32-bit word per cycle. A narrow store is masked to its width. Multi-word stores step both the source and the destination register numbers. The register files and the cache sit outside the block: the source word is read through a combinational read port, and each repaired word leaves on a write-back port.

Top module: `dfc_commit_unit`

## Requirements
- R1: A record pulse sets the flag of `rec_reg` in the bank chosen by `rec_float` (1 = floating) at the next edge. If `cfg_valid` and `cfg_log_en` are both high, it also fills the lowest-index free log entry with bank, register and address. If no entry is free, the log is left unchanged. A record is applied after any request accepted in the same cycle, so its flag survives a same-cycle commit of that register.
- R2: A commit (`req_op`=1) or clear (`req_op`=2) with `req_all`=0 clears only the flag of `req_reg` in bank `req_float`. Registers 32..63 form the upper half, which is gated by `avail_hi`; registers 0..31 form the lower half, gated by `avail_lo`. A request naming a register in an unavailable half is ignored completely.
- R3: With `req_all`=1, a commit treats its flag as set when any flag is set in an available half of the chosen bank. Both commit and clear then zero only the available halves.
- R4: `commit_exc` is high for one cycle, one cycle after an accepted commit, exactly when `cfg_valid` and `cfg_log_en` were high and the tested flag was set.
- R5: A commit that raises the exception, or any accepted clear made while logging is on, invalidates every valid log entry of the same bank whose register equals `req_reg` (any register when `req_all`=1). Entries left alone by a commit without an exception, or by a request made with logging off, stay matchable.
- R6: A clear request never raises `commit_exc`.
- R7: An accepted store (`req_op`=3) whose `req_addr` equals the address of a valid log entry raises `inv_req` for one cycle with `inv_addr` = `req_addr`, one cycle after acceptance. It uses the lowest-index match only. With no match, the store has no effect.
- R8: The forward writes N words, where N = 1 for `req_size` 0 (byte), 1 (half) and 2 (word), N = 2 for 3 (double) and N = 4 for 4 (quad). In forward cycle k, `src_reg` = `req_reg`+k and `src_float` = `req_float`. One cycle later `wb_valid` is high with `wb_reg` = logged register + k, `wb_float` = the logged bank, and `wb_data` = `src_data`, masked to 8 bits for a byte and to 16 bits for a half.
- R9: `busy` is high for exactly N cycles, starting the cycle after a matching store is accepted. While `busy` is high, requests are ignored, but records are still taken. After reset all flags and log entries are clear and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Log control setting is valid |
| cfg_log_en | input | 1 | Fault logging enabled |
| avail_lo | input | 1 | Lower half of the register banks usable |
| avail_hi | input | 1 | Upper half of the register banks usable |
| rec_valid | input | 1 | Deferred fault record strobe |
| rec_float | input | 1 | Record targets the floating bank |
| rec_reg | input | 6 | Faulting load's destination register |
| rec_addr | input | 32 | Faulting load's effective address |
| req_op | input | 2 | 0 idle, 1 commit, 2 clear flags, 3 recovering store |
| req_all | input | 1 | Commit or clear applies to the whole bank |
| req_float | input | 1 | Bank selection (commit, clear) or source bank (store) |
| req_reg | input | 6 | Target register, or first store source register |
| req_addr | input | 32 | Store address |
| req_size | input | 3 | Store size code |
| src_data | input | 32 | Source register word read back combinationally |
| busy | output | 1 | Forward in progress |
| commit_exc | output | 1 | Commit exception pulse |
| inv_req | output | 1 | Invalidate-and-flush request pulse |
| inv_addr | output | 32 | Address to invalidate |
| src_reg | output | 6 | Source register to read |
| src_float | output | 1 | Source register bank |
| wb_valid | output | 1 | Repaired word write strobe |
| wb_float | output | 1 | Destination bank |
| wb_reg | output | 6 | Destination register |
| wb_data | output | 32 | Repaired word |
| gr_ne | output | 64 | Integer bank deferred fault flags |
| fr_ne | output | 64 | Floating bank deferred fault flags |

## Verification
Both flag banks are visible on the ports, so a wrongly set or cleared flag is seen at the next clock edge. The log itself is hidden. A stale entry appears only when a later store to its address raises `inv_req` when it should not, or writes to the wrong register. A lost or misplaced entry shows up the same way through a missing invalidate. For that reason the bench follows each clear and each commit with stores to the addresses involved. A wrong forward counter or register step shows in `busy`, `src_reg` or `wb_reg` within the N cycles of the forward.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_COMMIT = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_STORE  = 2'd3
    } dfc_op_e;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DUAL = 3'd3,
        SZ_QUAD = 3'd4
    } dfc_size_e;

    // number of 32-bit words a store of the given size forwards (R8)
    function automatic logic [2:0] words_of(input logic [2:0] sz);
        case (sz)
            SZ_DUAL: return 3'd2;
            SZ_QUAD: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/dfc_flag_bank.sv
// Flag test and clear for one register bank (R2, R3)
module dfc_flag_bank #(
    parameter int NREG = 64
) (
    input  logic [NREG-1:0]         flags_q,
    input  logic                    act,
    input  logic                    all_regs,
    input  logic [$clog2(NREG)-1:0] sel_reg,
    input  logic                    avail_lo,
    input  logic                    avail_hi,
    output logic [NREG-1:0]         flags_d,
    output logic                    tested
);
    localparam int RW   = $clog2(NREG);
    localparam int HALF = NREG / 2;

    assign tested = all_regs
        ? ((avail_hi && |flags_q[NREG-1:HALF]) || (avail_lo && |flags_q[HALF-1:0]))
        : flags_q[sel_reg];

    for (genvar g = 0; g < NREG; g++) begin : g_bit
        localparam bit IS_HI = (g >= HALF);
        logic hit;
        assign hit = all_regs ? (IS_HI ? avail_hi : avail_lo) : (sel_reg == RW'(g));
        assign flags_d[g] = flags_q[g] & ~(act & hit);
    end

endmodule

// File: rtl/dfc_first_set.sv
// Lowest-index set bit finder
module dfc_first_set #(
    parameter int N = 4
) (
    input  logic [N-1:0]         vec,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dfc_commit_unit.sv
module dfc_commit_unit
    import dfc_pkg::*;
#(
    parameter int NREG = 64,
    parameter int NLOG = 4,
    parameter int AW   = 32,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_valid,
    input  logic                    cfg_log_en,
    input  logic                    avail_lo,
    input  logic                    avail_hi,
    input  logic                    rec_valid,
    input  logic                    rec_float,
    input  logic [$clog2(NREG)-1:0] rec_reg,
    input  logic [AW-1:0]           rec_addr,
    input  logic [1:0]              req_op,
    input  logic                    req_all,
    input  logic                    req_float,
    input  logic [$clog2(NREG)-1:0] req_reg,
    input  logic [AW-1:0]           req_addr,
    input  logic [2:0]              req_size,
    input  logic [DW-1:0]           src_data,
    output logic                    busy,
    output logic                    commit_exc,
    output logic                    inv_req,
    output logic [AW-1:0]           inv_addr,
    output logic [$clog2(NREG)-1:0] src_reg,
    output logic                    src_float,
    output logic                    wb_valid,
    output logic                    wb_float,
    output logic [$clog2(NREG)-1:0] wb_reg,
    output logic [DW-1:0]           wb_data,
    output logic [NREG-1:0]         gr_ne,
    output logic [NREG-1:0]         fr_ne
);
    localparam int RW   = $clog2(NREG);
    localparam int LW   = $clog2(NLOG);
    localparam int HALF = NREG / 2;

    typedef struct packed {
        logic [NREG-1:0]           gr_ne;
        logic [NREG-1:0]           fr_ne;
        logic [NLOG-1:0]           lg_v;
        logic [NLOG-1:0]           lg_f;
        logic [NLOG-1:0][RW-1:0]   lg_dst;
        logic [NLOG-1:0][AW-1:0]   lg_addr;
        logic                      exc;
        logic                      inv;
        logic [AW-1:0]             inv_addr;
        logic                      fwd;
        logic [2:0]                fwd_left;
        logic [2:0]                fwd_sz;
        logic                      fwd_f;
        logic                      fwd_sf;
        logic [RW-1:0]             fwd_dst;
        logic [RW-1:0]             fwd_src;
        logic                      wb;
        logic                      wb_f;
        logic [RW-1:0]             wb_reg;
        logic [DW-1:0]             wb_data;
    } state_t;

    state_t s_q, s_d;

    function automatic logic [DW-1:0] size_mask(input logic [DW-1:0] d, input logic [2:0] sz);
        case (sz)
            SZ_BYTE: return {{(DW-8){1'b0}}, d[7:0]};
            SZ_HALF: return {{(DW-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    // ---------------- request decode ----------------
    logic    accept;
    dfc_op_e op;
    logic    reg_ok;
    logic    log_on;
    logic    flag_act;

    assign accept   = !s_q.fwd;                                   // R9
    assign op       = accept ? dfc_op_e'(req_op) : OP_IDLE;
    assign reg_ok   = req_all || (req_reg[RW-1] ? avail_hi : avail_lo);   // R2
    assign log_on   = cfg_valid && cfg_log_en;
    assign flag_act = reg_ok && (op == OP_COMMIT || op == OP_CLEAR);

    // ---------------- flag banks (0 integer, 1 floating) ----------------
    logic [1:0][NREG-1:0] bank_q;
    logic [1:0][NREG-1:0] bank_d;
    logic [1:0]           bank_tested;

    assign bank_q[0] = s_q.gr_ne;
    assign bank_q[1] = s_q.fr_ne;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        dfc_flag_bank #(.NREG(NREG)) u_bank (
            .flags_q  (bank_q[b]),
            .act      (flag_act && (req_float == (b == 1))),
            .all_regs (req_all),
            .sel_reg  (req_reg),
            .avail_lo (avail_lo),
            .avail_hi (avail_hi),
            .flags_d  (bank_d[b]),
            .tested   (bank_tested[b])
        );
    end

    logic tested;
    logic exc_hit;
    logic kill_log;

    assign tested   = req_float ? bank_tested[1] : bank_tested[0];
    assign exc_hit  = log_on && tested && reg_ok && (op == OP_COMMIT);          // R4
    assign kill_log = exc_hit || (log_on && reg_ok && (op == OP_CLEAR));        // R5, R6

    // ---------------- log entry selection ----------------
    logic [NLOG-1:0] kill;
    logic [NLOG-1:0] match_vec;
    logic [NLOG-1:0] free_vec;

    always_comb begin
        for (int i = 0; i < NLOG; i++) begin
            kill[i] = kill_log && s_q.lg_v[i] && (s_q.lg_f[i] == req_float)
                      && (req_all || (s_q.lg_dst[i] == req_reg));
            match_vec[i] = s_q.lg_v[i] && (s_q.lg_addr[i] == req_addr);
            free_vec[i]  = !(s_q.lg_v[i] && !kill[i]);
        end
    end

    logic          match_hit;
    logic [LW-1:0] match_idx;
    logic          free_hit;
    logic [LW-1:0] free_idx;

    dfc_first_set #(.N(NLOG)) u_match (.vec(match_vec), .hit(match_hit), .idx(match_idx)); // R7
    dfc_first_set #(.N(NLOG)) u_free  (.vec(free_vec),  .hit(free_hit),  .idx(free_idx));  // R1

    // ---------------- next state ----------------
    always_comb begin
        s_d     = s_q;
        s_d.exc = exc_hit;
        s_d.inv = 1'b0;
        s_d.wb  = 1'b0;

        // one forwarded word per cycle (R8)
        if (s_q.fwd) begin
            s_d.wb       = 1'b1;
            s_d.wb_f     = s_q.fwd_f;
            s_d.wb_reg   = s_q.fwd_dst;
            s_d.wb_data  = size_mask(src_data, s_q.fwd_sz);
            s_d.fwd_dst  = s_q.fwd_dst + RW'(1);
            s_d.fwd_src  = s_q.fwd_src + RW'(1);
            s_d.fwd_left = s_q.fwd_left - 3'd1;
            s_d.fwd      = (s_q.fwd_left != 3'd1);
        end

        s_d.gr_ne = bank_d[0];
        s_d.fr_ne = bank_d[1];

        for (int i = 0; i < NLOG; i++) begin
            if (kill[i]) begin
                s_d.lg_v[i]    = 1'b0;
                s_d.lg_addr[i] = '0;
            end
        end

        // recovering store: invalidate and start forward (R7)
        if (op == OP_STORE && match_hit) begin
            s_d.inv      = 1'b1;
            s_d.inv_addr = req_addr;
            s_d.fwd      = 1'b1;
            s_d.fwd_left = words_of(req_size);
            s_d.fwd_sz   = req_size;
            s_d.fwd_f    = s_q.lg_f[match_idx];
            s_d.fwd_dst  = s_q.lg_dst[match_idx];
            s_d.fwd_src  = req_reg;
            s_d.fwd_sf   = req_float;
        end

        // record applied last so it wins over a same-cycle clear (R1)
        if (rec_valid) begin
            if (rec_float) s_d.fr_ne[rec_reg] = 1'b1;
            else           s_d.gr_ne[rec_reg] = 1'b1;
            if (log_on && free_hit) begin
                s_d.lg_v[free_idx]    = 1'b1;
                s_d.lg_f[free_idx]    = rec_float;
                s_d.lg_dst[free_idx]  = rec_reg;
                s_d.lg_addr[free_idx] = rec_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // ---------------- outputs ----------------
    assign busy       = s_q.fwd;
    assign commit_exc = s_q.exc;
    assign inv_req    = s_q.inv;
    assign inv_addr   = s_q.inv_addr;
    assign src_reg    = s_q.fwd_src;
    assign src_float  = s_q.fwd_sf;
    assign wb_valid   = s_q.wb;
    assign wb_float   = s_q.wb_f;
    assign wb_reg     = s_q.wb_reg;
    assign wb_data    = s_q.wb_data;
    assign gr_ne      = s_q.gr_ne;
    assign fr_ne      = s_q.fr_ne;

    localparam int UNUSED_HALF = HALF;

endmodule

// File: rtl/dfc_commit_chk.sv
module dfc_commit_chk #(
    parameter int NREG = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_valid,
    input logic                    cfg_log_en,
    input logic                    avail_lo,
    input logic                    avail_hi,
    input logic                    rec_valid,
    input logic                    rec_float,
    input logic [$clog2(NREG)-1:0] rec_reg,
    input logic [1:0]              req_op,
    input logic                    req_all,
    input logic                    req_float,
    input logic [$clog2(NREG)-1:0] req_reg,
    input logic                    busy,
    input logic                    commit_exc,
    input logic                    inv_req,
    input logic                    wb_valid,
    input logic [NREG-1:0]         gr_ne
);
    localparam int RW = $clog2(NREG);

    AST_EXC_NEEDS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        commit_exc |-> $past(cfg_valid && cfg_log_en)); // R4

    AST_EXC_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_exc |-> $past(req_op == 2'd1 && !busy)); // R4

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 2'd2 && !busy) |=> !commit_exc); // R6

    AST_INV_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> $past(req_op == 2'd3 && !busy)); // R7

    AST_INV_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> busy); // R9

    AST_WB_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(busy)); // R8

    AST_BUSY_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !commit_exc); // R9

    AST_GR_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 2'd1 && !busy && !req_all && !req_float
         && (req_reg[RW-1] ? avail_hi : avail_lo)
         && !(rec_valid && !rec_float && rec_reg == req_reg))
        |=> !gr_ne[$past(req_reg)]); // R2

endmodule

bind dfc_commit_unit dfc_commit_chk #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_log_en (cfg_log_en),
    .avail_lo   (avail_lo),
    .avail_hi   (avail_hi),
    .rec_valid  (rec_valid),
    .rec_float  (rec_float),
    .rec_reg    (rec_reg),
    .req_op     (req_op),
    .req_all    (req_all),
    .req_float  (req_float),
    .req_reg    (req_reg),
    .busy       (busy),
    .commit_exc (commit_exc),
    .inv_req    (inv_req),
    .wb_valid   (wb_valid),
    .gr_ne      (gr_ne)
);

// File: tb/sim_dfc_commit_unit.sv
module sim_dfc_commit_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_log_en = 1'b0, avail_lo = 1'b1, avail_hi = 1'b1;
    logic        rec_valid = 1'b0, rec_float = 1'b0;
    logic [5:0]  rec_reg = '0;
    logic [31:0] rec_addr = '0;
    logic [1:0]  req_op = '0;
    logic        req_all = 1'b0, req_float = 1'b0;
    logic [5:0]  req_reg = '0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] src_data;
    logic        busy, commit_exc, inv_req, src_float, wb_valid, wb_float;
    logic [31:0] inv_addr, wb_data;
    logic [5:0]  src_reg, wb_reg;
    logic [63:0] gr_ne, fr_ne;

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic [31:0] regval(input logic f, input logic [5:0] r);
        return (f ? 32'hF00D_0000 : 32'h1234_0000) ^ {r, r, r, r, r, 2'b01};
    endfunction

    assign src_data = regval(src_float, src_reg);

    dfc_commit_unit u0 (.*);

    int nchk = 0, nbad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_ne [2];
    bit          m_lv [4];
    bit          m_lf [4];
    int          m_ld [4];
    logic [31:0] m_la [4];
    bit          m_exc, m_inv, m_wb, m_wbf, m_ff, m_sf;
    logic [31:0] m_inva, m_wbd;
    int          m_wbr, m_left, m_dst, m_src, m_sz;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ne[0] = '0; m_ne[1] = '0;
            for (int i = 0; i < 4; i++) begin m_lv[i] = 0; m_lf[i] = 0; m_ld[i] = 0; m_la[i] = 0; end
            m_exc = 0; m_inv = 0; m_wb = 0; m_wbf = 0; m_ff = 0; m_sf = 0;
            m_inva = 0; m_wbd = 0; m_wbr = 0; m_left = 0; m_dst = 0; m_src = 0; m_sz = 0;
        end else begin
            int  op;
            bit  okr, tst, lon, killl;
            int  f;
            op  = (m_left == 0) ? int'(req_op) : 0;
            lon = cfg_valid && cfg_log_en;
            f   = int'(req_float);
            m_exc = 0; m_inv = 0; m_wb = 0;
            if (m_left > 0) begin
                logic [31:0] d;
                d = regval(m_sf, 6'(m_src));
                if (m_sz == 0) d = d & 32'hFF;
                if (m_sz == 1) d = d & 32'hFFFF;
                m_wb = 1; m_wbf = m_ff; m_wbr = m_dst; m_wbd = d;
                m_dst = (m_dst + 1) % 64; m_src = (m_src + 1) % 64; m_left--;
            end
            okr = req_all || (req_reg >= 32 ? avail_hi : avail_lo);
            if ((op == 1 || op == 2) && okr) begin
                if (req_all) tst = (avail_hi && m_ne[f][63:32] != 0) || (avail_lo && m_ne[f][31:0] != 0);
                else         tst = m_ne[f][req_reg];
                if (req_all) begin
                    if (avail_hi) m_ne[f][63:32] = '0;
                    if (avail_lo) m_ne[f][31:0] = '0;
                end else m_ne[f][req_reg] = 1'b0;
                killl = (op == 1) ? (lon && tst) : lon;
                m_exc = (op == 1) && lon && tst;
                for (int i = 0; i < 4; i++)
                    if (killl && m_lv[i] && int'(m_lf[i]) == f && (req_all || m_ld[i] == int'(req_reg))) begin
                        m_lv[i] = 0; m_la[i] = 0;
                    end
            end
            if (op == 3) begin
                for (int i = 0; i < 4; i++) begin
                    if (m_lv[i] && m_la[i] == req_addr) begin
                        m_inv = 1; m_inva = req_addr;
                        m_left = (req_size == 3) ? 2 : (req_size == 4) ? 4 : 1;
                        m_sz = int'(req_size); m_ff = m_lf[i]; m_dst = m_ld[i];
                        m_src = int'(req_reg); m_sf = req_float;
                        break;
                    end
                end
            end
            if (rec_valid) begin
                m_ne[rec_float][rec_reg] = 1'b1;
                if (lon) begin
                    for (int i = 0; i < 4; i++) begin
                        if (!m_lv[i]) begin
                            m_lv[i] = 1; m_lf[i] = rec_float; m_ld[i] = int'(rec_reg); m_la[i] = rec_addr;
                            break;
                        end
                    end
                end
            end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(gr_ne == m_ne[0], "R1/R2/R3 integer flags", gr_ne, m_ne[0]);
            chk(fr_ne == m_ne[1], "R1/R2/R3 floating flags", fr_ne, m_ne[1]);
            chk(commit_exc == m_exc, "R4 commit_exc", commit_exc, m_exc);
            chk(inv_req == m_inv, "R7 inv_req", inv_req, m_inv);
            if (m_inv) chk(inv_addr == m_inva, "R7 inv_addr", inv_addr, m_inva);
            chk(busy == (m_left > 0), "R9 busy", busy, m_left > 0);
            chk(wb_valid == m_wb, "R8 wb_valid", wb_valid, m_wb);
            if (m_wb) begin
                chk(wb_reg == 6'(m_wbr), "R8 wb_reg", wb_reg, m_wbr);
                chk(wb_float == m_wbf, "R8 wb_float", wb_float, m_wbf);
                chk(wb_data == m_wbd, "R8 wb_data", wb_data, m_wbd);
            end
            if (m_left > 0) begin
                chk(src_reg == 6'(m_src), "R8 src_reg", src_reg, m_src);
                chk(src_float == m_sf, "R8 src_float", src_float, m_sf);
            end
        end
    end

    // ---------------- drivers ----------------
    task automatic idle_all();
        req_op = 2'd0; req_all = 0; rec_valid = 0;
    endtask

    task automatic do_req(input logic [1:0] op, input bit all, input bit f, input logic [5:0] r,
                          input logic [31:0] a, input logic [2:0] sz);
        @(negedge clk);
        req_op = op; req_all = all; req_float = f; req_reg = r; req_addr = a; req_size = sz;
        @(negedge clk);
        idle_all();
    endtask

    task automatic do_rec(input bit f, input logic [5:0] r, input logic [31:0] a);
        @(negedge clk);
        rec_valid = 1; rec_float = f; rec_reg = r; rec_addr = a;
        @(negedge clk);
        idle_all();
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gr_ne == 0 && fr_ne == 0, "R9 reset flags", gr_ne | fr_ne, 0);
        chk(!busy && !commit_exc && !inv_req && !wb_valid, "R9 reset outputs", busy, 0);

        cfg_valid = 1; cfg_log_en = 1;
        do_rec(0, 6'd5, 32'h100);
        chk(gr_ne[5] == 1, "R1 record sets flag", gr_ne[5], 1);
        do_rec(0, 6'd40, 32'h200);
        do_rec(1, 6'd7, 32'h300);

        do_req(2'd3, 0, 0, 6'd10, 32'h100, 3'd2);
        chk(inv_req == 1 && inv_addr == 32'h100, "R7 store hit invalidates", inv_addr, 32'h100);
        chk(busy == 1, "R9 busy one word", busy, 1);
        @(negedge clk);
        chk(wb_valid && wb_reg == 6'd5 && wb_data == regval(0, 6'd10), "R8 word forward", wb_data, regval(0, 6'd10));
        chk(busy == 0, "R9 busy drops", busy, 0);

        do_req(2'd3, 0, 0, 6'd11, 32'h200, 3'd0);
        @(negedge clk);
        chk(wb_reg == 6'd40 && wb_data == (regval(0, 6'd11) & 32'hFF), "R8 byte mask", wb_data, regval(0, 6'd11) & 32'hFF);

        // quad store to floating entry, with a commit issued while busy
        @(negedge clk);
        req_op = 2'd3; req_reg = 6'd20; req_float = 0; req_addr = 32'h300; req_size = 3'd4;
        @(negedge clk);
        req_op = 2'd1; req_all = 0; req_float = 0; req_reg = 6'd5;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 2) idle_all();
            chk(commit_exc == 0, "R9 request ignored while busy", commit_exc, 0);
            chk(wb_valid && wb_float && wb_reg == 6'(7 + k) && wb_data == regval(0, 6'(20 + k)),
                "R8 quad forward word", wb_data, regval(0, 6'(20 + k)));
        end
        idle_all();
        chk(gr_ne[5] == 1, "R9 ignored commit left flag", gr_ne[5], 1);

        do_req(2'd1, 0, 0, 6'd5, 0, 0);
        chk(commit_exc == 1, "R4 flagged commit raises", commit_exc, 1);
        chk(gr_ne[5] == 0, "R2 commit clears flag", gr_ne[5], 0);
        do_req(2'd3, 0, 0, 6'd1, 32'h100, 3'd2);
        chk(inv_req == 0, "R5 committed entry gone", inv_req, 0);

        do_rec(0, 6'd13, 32'h200);
        do_req(2'd3, 0, 0, 6'd3, 32'h200, 3'd1);
        @(negedge clk);
        chk(wb_reg == 6'd13 && wb_data == (regval(0, 6'd3) & 32'hFFFF), "R7 lowest match wins", wb_reg, 13);

        avail_hi = 0;
        do_req(2'd1, 0, 0, 6'd40, 0, 0);
        chk(commit_exc == 0 && gr_ne[40] == 1, "R2 unavailable half ignored", gr_ne[40], 1);
        do_req(2'd1, 1, 0, 6'd0, 0, 0);
        chk(commit_exc == 1, "R3 all commit tests available half", commit_exc, 1);
        chk(gr_ne[13] == 0 && gr_ne[40] == 1, "R3 only available half cleared", gr_ne, 64'h1 << 40);
        do_req(2'd3, 0, 0, 6'd1, 32'h200, 3'd2);
        chk(inv_req == 0, "R5 all commit removes bank entries", inv_req, 0);
        avail_hi = 1;

        do_req(2'd2, 0, 1, 6'd7, 0, 0);
        chk(commit_exc == 0 && fr_ne[7] == 0, "R6 clear is quiet", commit_exc, 0);

        do_rec(0, 6'd50, 32'h500);
        cfg_log_en = 0;
        do_req(2'd1, 0, 0, 6'd50, 0, 0);
        chk(commit_exc == 0 && gr_ne[50] == 0, "R4 no exception with logging off", commit_exc, 0);
        cfg_log_en = 1;
        do_req(2'd3, 0, 0, 6'd2, 32'h500, 3'd2);
        chk(inv_req == 1, "R5 entry kept when logging off", inv_req, 1);
        settle();

        do_rec(0, 6'd1, 32'h601);
        do_rec(0, 6'd2, 32'h602);
        do_rec(0, 6'd3, 32'h603);
        do_rec(0, 6'd4, 32'h604);
        chk(gr_ne[4] == 1, "R1 flag set with log full", gr_ne[4], 1);
        do_req(2'd3, 0, 0, 6'd2, 32'h604, 3'd2);
        chk(inv_req == 0, "R1 full log takes no entry", inv_req, 0);

        do_rec(0, 6'd60, 32'h700);
        @(negedge clk);
        req_op = 2'd1; req_reg = 6'd60; req_float = 0;
        rec_valid = 1; rec_float = 0; rec_reg = 6'd60; rec_addr = 32'h700;
        @(negedge clk);
        idle_all();
        chk(commit_exc == 1 && gr_ne[60] == 1, "R1 record after same-cycle commit", gr_ne[60], 1);

        do_req(2'd1, 1, 1, 6'd0, 0, 0);
        chk(commit_exc == 0, "R3 empty bank commit quiet", commit_exc, 0);
        settle();

        // random traffic checked against the model
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            req_op    = 2'($urandom_range(0, 3));
            req_all   = ($urandom_range(0, 7) == 0);
            req_float = 1'($urandom_range(0, 1));
            req_reg   = 6'($urandom_range(0, 3) + (($urandom_range(0, 1) == 1) ? 30 : 0));
            req_addr  = 32'h10 + 32'($urandom_range(0, 3) * 4);
            req_size  = 3'($urandom_range(0, 4));
            rec_valid = ($urandom_range(0, 2) == 0);
            rec_float = 1'($urandom_range(0, 1));
            rec_reg   = 6'($urandom_range(0, 3) + (($urandom_range(0, 1) == 1) ? 30 : 0));
            rec_addr  = 32'h10 + 32'($urandom_range(0, 3) * 4);
            if ($urandom_range(0, 15) == 0) avail_hi = ~avail_hi;
            if ($urandom_range(0, 15) == 0) avail_lo = ~avail_lo;
            cfg_log_en = ($urandom_range(0, 7) != 0);
        end
        @(negedge clk);
        idle_all();
        settle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule